// File: doc/BRIEF.md
# Multiword DMA Strobe Timer

This block generates the per-word handshake waveform that a host uses to move data words to or from a drive in multiword DMA bursts. Software programs a packed 32-bit timing word, a word count and a direction, then pulses `start`. The block waits for the drive's request line, asserts acknowledge and holds it for a setup interval. It then issues one strobe per word. Each strobe has a programmed asserted width and is followed by a negated interval. The negated interval has separate values for reads and writes.

A one-cycle `word_strobe` pulse marks the cycle in which the data path transfers each word. The drive may withdraw its request between words, which stalls the burst with the strobe negated. An abort request closes the burst at the next word boundary. When the burst is over, acknowledge drops and `done` pulses once. All timing fields are counts of system clock cycles. At a 250 MHz clock, the fastest mode's 120 ns cycle with a 70 ns strobe becomes an 18-cycle strobe plus a 12-cycle negated interval.

Top module: `mwdma_strobe_timer`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `dack`, `strobe`, `word_strobe`, `done` and `busy` are all 0.
- R2: A `start` pulse with a nonzero word count makes `busy` high in the next cycle. `dack` stays low until `dreq` is sampled high, and rises in the cycle after that sample.
- R3: After `dack` rises, the strobe stays negated for `cfg_timing[7:0]` cycles before the first strobe.
- R4: Every strobe is asserted for `cfg_timing[15:8]` cycles, and `word_strobe` is high for exactly the last of those cycles.
- R5: After each strobe, the negated interval lasts `cfg_timing[23:16]` cycles when `wr_dir` was 0 (read) at start, and `cfg_timing[31:24]` cycles when it was 1 (write).
- R6: A timing field of value 0 behaves as a value of 1 cycle.
- R7: Exactly `word_count` strobes are issued. `dack` falls after the final negated interval. `done` is high for a single cycle, the first cycle with `dack` low.
- R8: If `dreq` is low at a word boundary, the block holds the strobe negated with `dack` high. The next strobe starts in the cycle after `dreq` is sampled high again.
- R9: An `abort` pulse during a burst ends it at the next word boundary with no further strobe. This includes an abort while still waiting for `dreq`, in which case `dack` never rises. `done` still pulses.
- R10: A `start` with `word_count` of 0 produces a `done` pulse in the cycle after `start`, and `dack` never rises.
- R11: The timing word, direction and word count are captured at `start`. Changing them during a burst has no effect on that burst.
- R12: A `start` pulse while a burst is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_timing | input | 4*FIELD_W | Packed timing: write negated [31:24], read negated [23:16], asserted width [15:8], setup [7:0] |
| start | input | 1 | One-cycle request to begin a burst |
| wr_dir | input | 1 | Direction: 1 write to drive, 0 read from drive |
| word_count | input | CNT_W | Number of words in the burst |
| dreq | input | 1 | Drive DMA request |
| abort | input | 1 | End the burst at the next word boundary |
| dack | output | 1 | DMA acknowledge to the drive |
| strobe | output | 1 | Read/write data strobe to the drive, active high |
| word_strobe | output | 1 | One-cycle pulse per transferred word for the data path |
| done | output | 1 | One-cycle pulse when the burst has closed |
| busy | output | 1 | High from the cycle after start until done |

## Verification
The bench builds the block with its defaults: 8-bit timing fields and a 16-bit word count. With 8-bit fields the full-speed mode at 250 MHz (an 18-cycle strobe) fits alongside single-cycle and zero-valued fields, so the clamp and both direction-dependent negated times are reachable in the same table. Word counts stay small (0 to 6), because the count width only scales the counter and does not change the sequencing at the boundaries of pause, abort and final word.

// File: rtl/mwdma_timer_pkg.sv
package mwdma_timer_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_WAIT_REQ = 3'd1,
    ST_SETUP    = 3'd2,
    ST_ACTIVE   = 3'd3,
    ST_NEGATE   = 3'd4,
    ST_PAUSE    = 3'd5,
    ST_FINISH   = 3'd6
  } seq_state_t;

  // positions of the fields inside the packed timing word, low to high
  localparam int unsigned FLD_SETUP  = 0;
  localparam int unsigned FLD_ACTIVE = 1;
  localparam int unsigned FLD_RD_NEG = 2;
  localparam int unsigned FLD_WR_NEG = 3;
  localparam int unsigned NUM_FLDS   = 4;

endpackage

// File: rtl/mwdma_cfg_latch.sv
module mwdma_cfg_latch
  import mwdma_timer_pkg::*;
#(
  parameter int unsigned FIELD_W = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        capture,
  input  logic [NUM_FLDS*FIELD_W-1:0] cfg,
  input  logic                        wr_dir,
  output logic [FIELD_W-1:0]          setup_m1,
  output logic [FIELD_W-1:0]          act_m1,
  output logic [FIELD_W-1:0]          neg_m1
);

  // each field becomes a terminal count: zero is treated as one cycle
  logic [FIELD_W-1:0] term [NUM_FLDS];

  for (genvar g = 0; g < NUM_FLDS; g++) begin : g_field
    logic [FIELD_W-1:0] raw;
    assign raw     = cfg[g*FIELD_W +: FIELD_W];
    assign term[g] = (raw == '0) ? '0 : raw - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      setup_m1 <= '0;
      act_m1   <= '0;
      neg_m1   <= '0;
    end else if (capture) begin
      setup_m1 <= term[FLD_SETUP];
      act_m1   <= term[FLD_ACTIVE];
      neg_m1   <= wr_dir ? term[FLD_WR_NEG] : term[FLD_RD_NEG];
    end
  end

endmodule

// File: rtl/mwdma_interval_ctr.sv
module mwdma_interval_ctr #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt_nxt,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_comb begin
    if (load)
      cnt_nxt = load_val;
    else if (cnt_q != '0)
      cnt_nxt = cnt_q - 1'b1;
    else
      cnt_nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nxt;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/mwdma_word_ctr.sv
module mwdma_word_ctr #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         rem_zero
);

  logic [W-1:0] rem_q;

  always_ff @(posedge clk) begin
    if (rst)
      rem_q <= '0;
    else if (load)
      rem_q <= load_val;
    else if (dec && rem_q != '0)
      rem_q <= rem_q - 1'b1;
  end

  assign rem_zero = (rem_q == '0);

endmodule

// File: rtl/mwdma_strobe_timer.sv
module mwdma_strobe_timer
  import mwdma_timer_pkg::*;
#(
  parameter int unsigned FIELD_W = 8,
  parameter int unsigned CNT_W   = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [4*FIELD_W-1:0]   cfg_timing,
  input  logic                   start,
  input  logic                   wr_dir,
  input  logic [CNT_W-1:0]       word_count,
  input  logic                   dreq,
  input  logic                   abort,
  output logic                   dack,
  output logic                   strobe,
  output logic                   word_strobe,
  output logic                   done,
  output logic                   busy
);

  seq_state_t state_q, state_n;

  logic               iv_load;
  logic [FIELD_W-1:0] iv_val;
  logic [FIELD_W-1:0] iv_nxt;
  logic               iv_zero;
  logic               wc_load;
  logic               wc_dec;
  logic               wc_zero;
  logic [FIELD_W-1:0] setup_m1, act_m1, neg_m1;
  logic               abort_q;
  logic               abort_any;

  mwdma_cfg_latch #(.FIELD_W(FIELD_W)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .capture  (wc_load),
    .cfg      (cfg_timing),
    .wr_dir   (wr_dir),
    .setup_m1 (setup_m1),
    .act_m1   (act_m1),
    .neg_m1   (neg_m1)
  );

  mwdma_interval_ctr #(.W(FIELD_W)) u_iv (
    .clk      (clk),
    .rst      (rst),
    .load     (iv_load),
    .load_val (iv_val),
    .cnt_nxt  (iv_nxt),
    .zero     (iv_zero)
  );

  mwdma_word_ctr #(.W(CNT_W)) u_wc (
    .clk      (clk),
    .rst      (rst),
    .load     (wc_load),
    .load_val (word_count),
    .dec      (wc_dec),
    .rem_zero (wc_zero)
  );

  // abort is remembered until the next word boundary closes the burst
  always_ff @(posedge clk) begin
    if (rst)
      abort_q <= 1'b0;
    else if (state_q == ST_IDLE || state_q == ST_FINISH)
      abort_q <= 1'b0;
    else if (abort)
      abort_q <= 1'b1;
  end

  assign abort_any = abort_q | abort;

  always_comb begin
    state_n = state_q;
    iv_load = 1'b0;
    iv_val  = '0;
    wc_load = 1'b0;
    wc_dec  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          wc_load = 1'b1;
          state_n = (word_count == '0) ? ST_FINISH : ST_WAIT_REQ;
        end
      end
      ST_WAIT_REQ: begin
        if (abort_any) begin
          state_n = ST_FINISH;
        end else if (dreq) begin
          state_n = ST_SETUP;
          iv_load = 1'b1;
          iv_val  = setup_m1;
        end
      end
      ST_SETUP: begin
        if (iv_zero) begin
          if (abort_any) begin
            state_n = ST_FINISH;
          end else if (dreq) begin
            state_n = ST_ACTIVE;
            iv_load = 1'b1;
            iv_val  = act_m1;
          end else begin
            state_n = ST_PAUSE;
          end
        end
      end
      ST_ACTIVE: begin
        if (iv_zero) begin
          state_n = ST_NEGATE;
          iv_load = 1'b1;
          iv_val  = neg_m1;
          wc_dec  = 1'b1;
        end
      end
      ST_NEGATE: begin
        if (iv_zero) begin
          if (wc_zero || abort_any) begin
            state_n = ST_FINISH;
          end else if (dreq) begin
            state_n = ST_ACTIVE;
            iv_load = 1'b1;
            iv_val  = act_m1;
          end else begin
            state_n = ST_PAUSE;
          end
        end
      end
      ST_PAUSE: begin
        if (abort_any) begin
          state_n = ST_FINISH;
        end else if (dreq) begin
          state_n = ST_ACTIVE;
          iv_load = 1'b1;
          iv_val  = act_m1;
        end
      end
      ST_FINISH: state_n = ST_IDLE;
      default:   state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_n;
  end

  // outputs are registered copies of the next-state decode
  always_ff @(posedge clk) begin
    if (rst) begin
      dack        <= 1'b0;
      strobe      <= 1'b0;
      word_strobe <= 1'b0;
      done        <= 1'b0;
      busy        <= 1'b0;
    end else begin
      dack        <= (state_n == ST_SETUP) || (state_n == ST_ACTIVE) ||
                     (state_n == ST_NEGATE) || (state_n == ST_PAUSE);
      strobe      <= (state_n == ST_ACTIVE);
      word_strobe <= (state_n == ST_ACTIVE) && (iv_nxt == '0);
      done        <= (state_n == ST_FINISH);
      busy        <= (state_n != ST_IDLE);
    end
  end

endmodule

// File: rtl/mwdma_strobe_timer_chk.sv
module mwdma_strobe_timer_chk (
  input logic clk,
  input logic rst,
  input logic dreq,
  input logic dack,
  input logic strobe,
  input logic word_strobe,
  input logic done,
  input logic busy
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!dack && !strobe && !done && !busy));

  assert_ack_follows_req_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(dack) |-> $past(dreq));

  assert_strobe_under_ack_R4: assert property (@(posedge clk) disable iff (rst)
    strobe |-> dack);

  assert_word_pulse_in_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    word_strobe |-> strobe);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_released_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (!dack && !strobe));

  assert_strobe_needs_req_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(strobe) |-> $past(dreq));

  assert_idle_no_ack_R2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !dack);

endmodule

bind mwdma_strobe_timer mwdma_strobe_timer_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .dreq        (dreq),
  .dack        (dack),
  .strobe      (strobe),
  .word_strobe (word_strobe),
  .done        (done),
  .busy        (busy)
);

// File: tb/mwdma_strobe_timer_test.sv
module mwdma_strobe_timer_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] cfg_timing = '0;
  logic        start = 1'b0;
  logic        wr_dir = 1'b0;
  logic [15:0] word_count = '0;
  logic        dreq = 1'b0;
  logic        abort = 1'b0;
  logic        dack, strobe, word_strobe, done, busy;

  always #2 clk = ~clk;

  mwdma_strobe_timer uut (
    .clk(clk), .rst(rst), .cfg_timing(cfg_timing), .start(start),
    .wr_dir(wr_dir), .word_count(word_count), .dreq(dreq), .abort(abort),
    .dack(dack), .strobe(strobe), .word_strobe(word_strobe),
    .done(done), .busy(busy)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // {timing word, direction nibble, words, expected dack-high cycles}
  localparam logic [63:0] VEC [8] = '{
    {32'h05030402, 4'h0, 12'd3, 16'd23},
    {32'h05030402, 4'h1, 12'd3, 16'd29},
    {32'h02010101, 4'h0, 12'd4, 16'd9},
    {32'h00000000, 4'h1, 12'd2, 16'd5},
    {32'h0C0C1207, 4'h1, 12'd2, 16'd67},
    {32'h01090203, 4'h0, 12'd5, 16'd58},
    {32'h05030402, 4'h1, 12'd1, 16'd11},
    {32'h02090301, 4'h1, 12'd3, 16'd16}
  };

  int m_setup, m_hi_min, m_hi_max, m_gap_min, m_gap_max, m_last_gap;
  int m_ws, m_rises, m_total, m_done, m_done_cyc, m_first_dack, m_post_strobe;
  int m_done_bad, m_busy1;

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clampv(input logic [7:0] f);
    return (f == 8'd0) ? 1 : int'(f);
  endfunction

  task automatic run_burst(input logic [31:0] c, input logic d, input int n,
                           input int req_delay, input int pause_word,
                           input int abort_word, input bit mid_change);
    int  hi_run = 0, lo_run = 0, post = -1, pause_left = 0;
    bit  prev_strobe = 0, prev_dack = 0;
    m_setup = -1; m_hi_min = 100000; m_hi_max = 0; m_gap_min = 100000;
    m_gap_max = 0; m_last_gap = -1; m_ws = 0; m_rises = 0; m_total = 0;
    m_done = 0; m_done_cyc = -1; m_first_dack = -1; m_post_strobe = 0;
    m_done_bad = 0; m_busy1 = 0;
    @(negedge clk);
    cfg_timing = c; wr_dir = d; word_count = 16'(n); start = 1'b1;
    dreq = (req_delay == 0); abort = 1'b0;
    for (int i = 1; i < 4000; i++) begin
      @(negedge clk);
      if (i == 1) m_busy1 = busy;
      if (dack) m_total++;
      if (dack && !prev_dack && m_first_dack < 0) m_first_dack = i;
      if (strobe) begin
        hi_run++;
        if (!prev_strobe) begin
          m_rises++;
          if (m_rises == 1) m_setup = lo_run;
          else begin
            if (lo_run < m_gap_min) m_gap_min = lo_run;
            if (lo_run > m_gap_max) m_gap_max = lo_run;
          end
          lo_run = 0;
        end
      end else begin
        if (prev_strobe) begin
          if (hi_run < m_hi_min) m_hi_min = hi_run;
          if (hi_run > m_hi_max) m_hi_max = hi_run;
          hi_run = 0;
        end
        if (dack) lo_run++;
      end
      if (prev_dack && !dack && m_rises > 0) begin
        m_last_gap = lo_run;
        if (lo_run < m_gap_min) m_gap_min = lo_run;
        if (lo_run > m_gap_max) m_gap_max = lo_run;
        lo_run = 0;
      end
      if (word_strobe) m_ws++;
      if (post >= 0 && strobe) m_post_strobe++;
      if (done) begin
        m_done++;
        if (m_done_cyc < 0) m_done_cyc = i;
        if (dack) m_done_bad = 1;
      end
      prev_strobe = strobe;
      prev_dack   = dack;
      // drive the next cycle's inputs
      start = 1'b0;
      if (i == req_delay) dreq = 1'b1;
      if (pause_word > 0 && word_strobe && m_ws == pause_word) begin
        dreq = 1'b0; pause_left = 6;
      end else if (pause_left > 0) begin
        pause_left--;
        if (pause_left == 0) dreq = 1'b1;
      end
      if (abort_word > 0 && word_strobe && m_ws == abort_word) abort = 1'b1;
      else if (abort_word == 0 && i == 2) abort = 1'b1;
      else abort = 1'b0;
      if (mid_change && word_strobe && m_ws == 1) begin
        cfg_timing = 32'h01010101; wr_dir = !d; word_count = 16'd1; start = 1'b1;
      end
      if (done && post < 0) post = 0;
      else if (post >= 0) post++;
      if (post >= 3) break;
    end
    dreq = 1'b0; abort = 1'b0; start = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state, with request and start stimulus present
    rst = 1'b1; dreq = 1'b1; start = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 dack in reset", int'(dack), 0);
    chk("R1 busy in reset", int'(busy), 0);
    start = 1'b0; dreq = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    chk("R1 outputs after release", int'({dack, strobe, word_strobe, done, busy}), 0);

    // table of bursts: R3 R4 R5 R6 R7
    foreach (VEC[k]) begin
      logic [31:0] c;
      logic        d;
      int          n, tot, s, a, g;
      c   = VEC[k][63:32];
      d   = VEC[k][28];
      n   = int'(VEC[k][27:16]);
      tot = int'(VEC[k][15:0]);
      s   = clampv(c[7:0]);
      a   = clampv(c[15:8]);
      g   = d ? clampv(c[31:24]) : clampv(c[23:16]);
      run_burst(c, d, n, 0, -1, -1, 1'b0);
      chk("R3 setup", m_setup, s);
      chk("R4 strobe min width", m_hi_min, a);
      chk("R4 strobe max width", m_hi_max, a);
      chk("R4 word pulses", m_ws, n);
      chk("R5 negated min", m_gap_min, g);
      chk("R5 negated max", m_gap_max, g);
      chk("R7 final negated", m_last_gap, g);
      chk("R7 strobe count", m_rises, n);
      chk("R7 dack cycles", m_total, tot);
      chk("R7 done pulses", m_done, 1);
      chk("R7 done with dack low", m_done_bad, 0);
    end

    // R6: all-zero timing word behaves as one cycle each
    run_burst(32'h00000000, 1'b0, 3, 0, -1, -1, 1'b0);
    chk("R6 zero setup", m_setup, 1);
    chk("R6 zero width", m_hi_max, 1);
    chk("R6 zero negated", m_gap_max, 1);

    // R2: request arrives late
    run_burst(32'h05030402, 1'b0, 2, 5, -1, -1, 1'b0);
    chk("R2 busy after start", m_busy1, 1);
    chk("R2 dack after dreq", m_first_dack, 6);
    chk("R2 words", m_rises, 2);

    // R8: request withdrawn after the second word for 6 cycles
    run_burst(32'h05020301, 1'b0, 4, 0, 2, -1, 1'b0);
    chk("R8 paused gap", m_gap_max, 6);
    chk("R8 normal gap", m_gap_min, 2);
    chk("R8 words", m_rises, 4);
    chk("R8 done", m_done, 1);

    // R9: abort during word 2 of 6
    run_burst(32'h05030402, 1'b1, 6, 0, -1, 2, 1'b0);
    chk("R9 strobes before abort", m_rises, 2);
    chk("R9 final negated", m_last_gap, 5);
    chk("R9 done", m_done, 1);
    chk("R9 no strobe after done", m_post_strobe, 0);

    // R9: abort while waiting for request
    run_burst(32'h05030402, 1'b0, 4, 50, -1, 0, 1'b0);
    chk("R9 no dack when aborted early", m_first_dack, -1);
    chk("R9 early abort done cycle", m_done_cyc, 3);

    // R10: zero word count
    run_burst(32'h05030402, 1'b0, 0, 0, -1, -1, 1'b0);
    chk("R10 done cycle", m_done_cyc, 1);
    chk("R10 no dack", m_first_dack, -1);
    chk("R10 no strobe", m_rises, 0);

    // R11 R12: inputs changed and start pulsed mid-burst
    run_burst(32'h05030402, 1'b0, 3, 0, -1, -1, 1'b1);
    chk("R11 width kept", m_hi_max, 4);
    chk("R11 negated kept", m_gap_max, 3);
    chk("R11 word count kept", m_rises, 3);
    chk("R12 single done", m_done, 1);
    chk("R12 total dack", m_total, 23);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule